// File: doc/BRIEF.md
# Converter Configuration Write-Protect Controller

This block is the register file in front of a data converter. It holds a group of configuration registers, a trigger-control register with an arm bit, a power register with an enable bit, and a status register. Once configured, the registers are frozen in two steps. Setting the arm bit makes the configuration group read-only. A power-up request then also freezes the trigger-control register and raises the lock status.

The power-up request has two possible sources, picked by a source-select bit held in the configuration group. It is either the software enable bit or an external sequencer input. The external input is resynchronized before it can raise the lock. To unlock, first withdraw the power-up request, then clear the arm bit. The arm bit cannot be cleared while the lock is up.

The bus is simple. A write takes effect on the clock edge where `bus_wr` is high. Read data is a combinational decode of `bus_addr`. A write to a protected register is dropped without notice, and reads are always allowed.

Top module: `cfg_lock_ctrl`

## Requirements
- R1: After reset every register reads 0, `lock_stat` is 0 and `cfg_frozen` is 0.
- R2: Configuration registers sit at addresses 0 to NCFG-1 and store the full data word. While the arm bit is 0, a write is stored at the clock edge and reads back on the following cycle.
- R3: While the arm bit (bit 0 at address NCFG) is 1, writes to the configuration registers are ignored, their contents are unchanged, and they still read back. `cfg_frozen` mirrors the arm bit.
- R4: Bit 0 of configuration register 0 selects the power-up source: 0 selects the software enable bit, and 1 selects the external `ext_arm` input.
- R5: With the software source, `lock_stat` and status bit 8 read 1 starting on the cycle right after the clock edge that writes 1 to the enable bit (bit 0 at address NCFG+1). They return to 0 right after that bit is written back to 0.
- R6: With the external source, `lock_stat` follows `ext_arm` delayed by exactly SYNC+1 clock edges. With the defaults that is 3 edges, both when rising and when falling.
- R7: While `lock_stat` is 1, writes to the trigger-control register are ignored, including a write that clears the arm bit. The arm bit can be cleared only after the power-up request has gone away.
- R8: The status register sits at address NCFG+2. Bit 8 is the read-only lock status and bit 0 is a read/write start bit. All other bits read 0.
- R9: The trigger-control and power registers store only bit 0, and their other bits read 0. The power register and the status start bit can be written whatever the lock state.
- R10: Addresses above NCFG+2 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized internally |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` |
| ext_arm | input | 1 | External power-up request from the sequencer, asynchronous |
| lock_stat | output | 1 | Lock status (trigger-control register frozen) |
| cfg_frozen | output | 1 | Configuration group frozen (arm bit) |
| cfg_flat | output | NCFG*DW | All configuration registers, register i at bits i*DW upward |

## Verification
The bench builds the block with NCFG=6, DW=16, AW=4 and SYNC=2. This places the trigger, power and status registers at addresses 6, 7 and 8. It leaves addresses 9 to 15 unmapped, which brings the reads and writes of R10 within reach. The external-request delay is 3 edges, so the bench can count the exact rise and fall cycles of R6. Random writes to all sixteen addresses, combined with random toggling of `ext_arm`, drive the design through both lock sources. They also produce writes that are rejected in every lock state.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

  // Address regions of the register file
  typedef enum logic [2:0] {
    RGN_CFG,
    RGN_TRIG,
    RGN_PWR,
    RGN_STAT,
    RGN_NONE
  } region_e;

  localparam int LOCK_BIT  = 8;  // lock status position in the status register
  localparam int START_BIT = 0;  // start bit position in the status register
  localparam int TSEL_BIT  = 0;  // source select position in configuration register 0

endpackage

// File: rtl/cfg_lock_rst_sync.sv
module cfg_lock_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) shift_q <= '0;
    else           shift_q <= shift_d;
  end

  assign rst_n_out = shift_q[STAGES-1];

endmodule

// File: rtl/cfg_lock_arm_sync.sv
module cfg_lock_arm_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_in,
  output logic arm_q
);

  localparam int LAT = SYNC + 1;
  localparam int AGW = $clog2(LAT + 1);

  logic [SYNC-1:0] sync_q;
  logic [SYNC-1:0] sync_d;
  logic            out_q;
  logic            out_d;

  always_comb begin
    sync_d = {sync_q[SYNC-2:0], arm_in};
    out_d  = sync_q[SYNC-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      out_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      out_q  <= out_d;
    end
  end

  assign arm_q = out_q;

  // Cycles since reset, saturating, so the latency check never looks before reset
  logic [AGW-1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 age_q <= '0;
    else if (age_q != AGW'(LAT)) age_q <= age_q + 1'b1;
  end

  // R6: the request appears on the output exactly LAT edges later
  a_r6_arm_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == AGW'(LAT)) |-> (arm_q == $past(arm_in, LAT)));

endmodule

// File: rtl/cfg_lock_bank.sv
module cfg_lock_bank
  import cfg_lock_pkg::*;
#(
  parameter int NCFG = 6,
  parameter int DW   = 16,
  parameter int AW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic              arm_q,
  output logic [DW-1:0]     rdata,
  output logic              lock,
  output logic              trig_en,
  output logic [NCFG*DW-1:0] cfg_flat
);

  localparam logic [AW-1:0] A_TRIG = AW'(NCFG);
  localparam logic [AW-1:0] A_PWR  = AW'(NCFG + 1);
  localparam logic [AW-1:0] A_STAT = AW'(NCFG + 2);
  localparam logic [DW-1:0] STAT_MASK = (DW'(1) << LOCK_BIT) | (DW'(1) << START_BIT);

  region_e         rgn;
  logic [DW-1:0]   cfg_q [NCFG];
  logic            trig_q, trig_d;
  logic            on_q, on_d;
  logic            start_q, start_d;
  logic            tsel;

  // Address decode
  always_comb begin
    if (addr < A_TRIG)       rgn = RGN_CFG;
    else if (addr == A_TRIG) rgn = RGN_TRIG;
    else if (addr == A_PWR)  rgn = RGN_PWR;
    else if (addr == A_STAT) rgn = RGN_STAT;
    else                     rgn = RGN_NONE;
  end

  // Configuration group: one register per address, frozen while armed
  for (genvar i = 0; i < NCFG; i++) begin : g_cfg
    logic          we;
    logic [DW-1:0] nxt;

    always_comb begin
      we  = wr && (rgn == RGN_CFG) && (addr == AW'(i)) && !trig_q;
      nxt = we ? wdata : cfg_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[i] <= '0;
      else        cfg_q[i] <= nxt;
    end

    assign cfg_flat[i*DW +: DW] = cfg_q[i];

    // R3: an armed configuration register keeps its value through a write
    a_r3_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == AW'(i) && trig_en) |=> $stable(cfg_q[i]));
  end

  assign tsel = cfg_q[0][TSEL_BIT];

  // Power-up request select: software enable or synchronized external input
  assign lock    = tsel ? arm_q : on_q;
  assign trig_en = trig_q;

  // Next state of the control bits
  always_comb begin
    trig_d  = trig_q;
    on_d    = on_q;
    start_d = start_q;
    if (wr) begin
      unique case (rgn)
        RGN_TRIG: if (!lock) trig_d = wdata[0];
        RGN_PWR:  on_d    = wdata[0];
        RGN_STAT: start_d = wdata[START_BIT];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q  <= 1'b0;
      on_q    <= 1'b0;
      start_q <= 1'b0;
    end else begin
      trig_q  <= trig_d;
      on_q    <= on_d;
      start_q <= start_d;
    end
  end

  // Read decode
  always_comb begin
    rdata = '0;
    unique case (rgn)
      RGN_CFG: begin
        for (int i = 0; i < NCFG; i++) begin
          if (addr == AW'(i)) rdata = cfg_q[i];
        end
      end
      RGN_TRIG: rdata[0] = trig_q;
      RGN_PWR:  rdata[0] = on_q;
      RGN_STAT: begin
        rdata[LOCK_BIT]  = lock;
        rdata[START_BIT] = start_q;
      end
      default:  rdata = '0;
    endcase
  end

  // R7: the trigger-control register ignores writes while locked
  a_r7_trig_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_TRIG && lock) |=> $stable(trig_en));

  // R5: software enable raises the lock on the next cycle
  a_r5_sw_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_PWR && wdata[0] && !tsel) |=> lock);

  // R8: reserved status bits never read 1
  a_r8_stat_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_STAT) |-> ((rdata & ~STAT_MASK) == '0));

  // R8: status bit 8 reports the lock
  a_r8_stat_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_STAT) |-> (rdata[LOCK_BIT] == lock));

  // R10: unmapped addresses read 0
  a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > A_STAT) |-> (rdata == '0));

endmodule

// File: rtl/cfg_lock_ctrl.sv
module cfg_lock_ctrl #(
  parameter int NCFG = 6,
  parameter int DW   = 16,
  parameter int AW   = 4,
  parameter int SYNC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic               ext_arm,
  output logic               lock_stat,
  output logic               cfg_frozen,
  output logic [NCFG*DW-1:0] cfg_flat
);

  logic rst_n_i;
  logic arm_q;

  cfg_lock_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_i)
  );

  cfg_lock_arm_sync #(.SYNC(SYNC)) u_arm (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .arm_in (ext_arm),
    .arm_q  (arm_q)
  );

  cfg_lock_bank #(.NCFG(NCFG), .DW(DW), .AW(AW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .arm_q    (arm_q),
    .rdata    (bus_rdata),
    .lock     (lock_stat),
    .trig_en  (cfg_frozen),
    .cfg_flat (cfg_flat)
  );

  // R7: the lock never stands while the arm bit is being cleared by an accepted write
  a_r7_order: assert property (@(posedge clk) disable iff (!rst_n_i)
    (lock_stat && cfg_frozen) |=> (cfg_frozen || !$past(lock_stat)));

endmodule

// File: tb/cfg_lock_ctrl_bench.sv
module cfg_lock_ctrl_bench;

  localparam int NCFG = 6;
  localparam int DW   = 16;
  localparam int AW   = 4;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               bus_wr;
  logic [AW-1:0]      bus_addr;
  logic [DW-1:0]      bus_wdata;
  logic [DW-1:0]      bus_rdata;
  logic               ext_arm;
  logic               lock_stat;
  logic               cfg_frozen;
  logic [NCFG*DW-1:0] cfg_flat;

  always #5 clk = ~clk;

  cfg_lock_ctrl #(.NCFG(NCFG), .DW(DW), .AW(AW), .SYNC(SYNC)) u_cfg_lock_ctrl (
    .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .ext_arm, .lock_stat, .cfg_frozen, .cfg_flat
  );

  // Reference model built from the requirements
  logic [DW-1:0]  m_cfg [NCFG];
  logic           m_trig, m_on, m_start;
  logic [LAT-1:0] m_pipe;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  function automatic logic m_lock();
    return m_cfg[0][0] ? m_pipe[LAT-1] : m_on;
  endfunction

  function automatic logic [DW-1:0] m_read(input int a);
    logic [DW-1:0] r;
    r = '0;
    if (a < NCFG)           r = m_cfg[a];
    else if (a == NCFG)     r[0] = m_trig;
    else if (a == NCFG + 1) r[0] = m_on;
    else if (a == NCFG + 2) begin r[8] = m_lock(); r[0] = m_start; end
    return r;
  endfunction

  function automatic string req_of(input int a);
    if (a < NCFG)           return m_trig ? "R3" : "R2";
    else if (a == NCFG)     return "R7";
    else if (a == NCFG + 1) return "R9";
    else if (a == NCFG + 2) return "R8";
    return "R10";
  endfunction

  task automatic check(input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NCFG; i++) m_cfg[i] = '0;
    m_trig = 0; m_on = 0; m_start = 0; m_pipe = '0;
  endtask

  // One bus cycle, called at a falling edge; checks the state before the edge
  task automatic step(input logic w, input int a, input logic [DW-1:0] d);
    logic lk;
    bus_wr = w; bus_addr = AW'(a); bus_wdata = d;
    #1;
    check(req_of(a), bus_rdata, m_read(a));
    check(m_cfg[0][0] ? "R6" : "R5", DW'(lock_stat), DW'(m_lock()));
    check("R3", DW'(cfg_frozen), DW'(m_trig));
    @(posedge clk);
    lk = m_lock();
    if (w) begin
      if (a < NCFG)           begin if (!m_trig) m_cfg[a] = d; end
      else if (a == NCFG)     begin if (!lk) m_trig = d[0]; end
      else if (a == NCFG + 1) m_on = d[0];
      else if (a == NCFG + 2) m_start = d[0];
    end
    m_pipe = {m_pipe[LAT-2:0], ext_arm};
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, NCFG + 2, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; ext_arm = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: everything reads 0 after reset
    for (int a = 0; a < (1 << AW); a++) begin
      bus_addr = AW'(a); #1;
      check("R1", bus_rdata, '0);
      @(negedge clk);
    end
    check("R1", DW'(lock_stat), '0);
    check("R1", DW'(cfg_frozen), '0);

    // R2: configuration writes and readback
    for (int i = 0; i < NCFG; i++) step(1'b1, i, DW'(16'hA5C0 + i * 2));
    for (int i = 0; i < NCFG; i++) step(1'b0, i, '0);
    check("R2", cfg_flat[DW +: DW], 16'hA5C2);

    // R9 / R10: narrow control registers and unmapped space
    step(1'b1, NCFG, 16'hFFFE);
    step(1'b1, NCFG + 1, 16'hFFFE);
    step(1'b1, 12, 16'hFFFF);
    step(1'b0, NCFG, '0);
    step(1'b0, NCFG + 1, '0);
    step(1'b0, 12, '0);

    // R8: status start bit writable, lock bit not
    step(1'b1, NCFG + 2, 16'hFFFF);
    step(1'b0, NCFG + 2, '0);
    check("R8", bus_rdata, 16'h0001);

    // R3: arm freezes the configuration group
    step(1'b1, NCFG, 16'h0001);
    step(1'b1, 1, 16'h1234);
    step(1'b0, 1, '0);
    check("R3", bus_rdata, 16'hA5C2);

    // R5: software enable locks on the next cycle
    step(1'b1, NCFG + 1, 16'h0001);
    check("R5", DW'(lock_stat), 16'h0001);
    // R7: clearing the arm bit while locked is refused
    step(1'b1, NCFG, 16'h0000);
    check("R7", DW'(cfg_frozen), 16'h0001);
    step(1'b1, NCFG + 1, 16'h0000);
    check("R5", DW'(lock_stat), 16'h0000);
    step(1'b1, NCFG, 16'h0000);
    check("R7", DW'(cfg_frozen), 16'h0000);

    // R4 / R6: external source with its fixed latency
    step(1'b1, 0, 16'h0001);
    step(1'b1, NCFG + 1, 16'h0001);
    check("R4", DW'(lock_stat), 16'h0000);
    step(1'b1, NCFG, 16'h0001);
    ext_arm = 1'b1;
    idle(2);
    check("R6", DW'(lock_stat), 16'h0000);
    idle(1);
    check("R6", DW'(lock_stat), 16'h0001);
    step(1'b1, NCFG, 16'h0000);
    check("R7", DW'(cfg_frozen), 16'h0001);
    ext_arm = 1'b0;
    idle(2);
    check("R6", DW'(lock_stat), 16'h0001);
    idle(1);
    check("R6", DW'(lock_stat), 16'h0000);
    step(1'b1, NCFG, 16'h0000);
    check("R7", DW'(cfg_frozen), 16'h0000);

    // Random mix of writes and external request changes
    for (int n = 0; n < 4000; n++) begin
      int a;
      logic w;
      if (($urandom() % 8) == 0) ext_arm = ~ext_arm;
      a = int'($urandom() % (1 << AW));
      w = (($urandom() % 10) < 7);
      step(w, a, DW'($urandom()));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule